// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block adds four unsigned integers of equal width in pure combinational logic. Carries are not passed along a row until the very end. A first layer of per-bit full adders squeezes three operands into two vectors: a sum vector and a carry vector whose weight is one position higher. A second layer of the same kind merges those two vectors with the fourth operand. Only then does one carry-propagate adder turn the remaining pair into a binary result.

The result is two bits wider than the operands, so the largest possible total (four times the all-ones operand) always fits. The block has no clock and holds no state. It suits use inside a multiplier's partial-product tree, or anywhere several values must be summed with a short logic depth.

Top module: `quad_csa_adder`

## Requirements
- R1: For any four N-bit unsigned inputs, `total` equals the arithmetic sum of the four inputs, expressed in N+2 bits.
- R2: When all four inputs are zero, `total` is zero.
- R3: When all four inputs are all ones, `total` equals 4*(2^N-1), and its most significant bit is set.
- R4: The first compressor layer keeps the value of the three operands it takes. With three all-ones operands and a zero fourth operand, `total` equals 3*(2^N-1).
- R5: The second layer merges the first layer's sum vector, its carry vector shifted one place left, and the fourth operand without changing their value. With alternating 0x55/0xAA patterns on the four inputs, `total` equals their sum.
- R6: The final carry-propagate adder never produces a carry out of bit N+1, so no bit of the total is lost. A carry rippling through all N low bits (for example 0xFF plus 0x01) appears at bit N.
- R7: The result does not depend on which input port carries which operand: permuting the operands leaves `total` unchanged.
- R8: When only one input is non-zero, `total` equals that input, whichever of the four ports carries it.
- R9: The block is correct for any width N of 2 or more. The default N is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand, unsigned |
| op_b | input | N | Second operand, unsigned |
| op_c | input | N | Third operand, unsigned |
| op_d | input | N | Fourth operand; enters at the second compressor layer |
| total | output | N+2 | Sum of the four operands |

## Verification
The bench builds two copies of the adder. The first uses the default N=8 and is driven with the table of corner patterns, with random vectors and with operand permutations. The second uses N=2, which keeps the input space at 256 combinations, so every input combination is applied and compared with the behavioural sum. At that narrow width, every carry path through both compressor layers and the final adder is exercised, including the path into the top result bit.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    // one column of a 3:2 compressor
    function automatic fa_out_t fa_bit(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/csa_compress.sv
module csa_compress
    import csa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] cry_v
);

    // independent full adder per column, no carry between columns
    for (genvar i = 0; i < W; i++) begin : g_col
        fa_out_t fa;
        always_comb begin
            fa       = fa_bit(in_x[i], in_y[i], in_z[i]);
            sum_v[i] = fa.s;
            cry_v[i] = fa.c;
        end
    end

endmodule

// File: rtl/csa_final_add.sv
module csa_final_add
    import csa_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_s,
    output logic         add_co
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    // row addition: the only place carries travel between columns
    for (genvar i = 0; i < W; i++) begin : g_rip
        fa_out_t fa;
        always_comb begin
            fa          = fa_bit(add_x[i], add_y[i], chain[i]);
            add_s[i]    = fa.s;
            chain[i+1]  = fa.c;
        end
    end

    assign add_co = chain[W];

endmodule

// File: rtl/quad_csa_adder.sv
module quad_csa_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] op_c,
    input  logic [N-1:0] op_d,
    output logic [N+1:0] total
);

    localparam int W1 = N;
    localparam int W2 = N + 1;
    localparam int WF = N + 2;

    // layer 1 outputs
    logic [W1-1:0] s1;
    logic [W1-1:0] c1;
    // layer 2 inputs and outputs
    logic [W2-1:0] l2_x;
    logic [W2-1:0] l2_y;
    logic [W2-1:0] l2_z;
    logic [W2-1:0] s2;
    logic [W2-1:0] c2;
    // final adder inputs
    logic [WF-1:0] f_x;
    logic [WF-1:0] f_y;
    logic          f_co;

    csa_compress #(.W(W1)) u_lay1 (
        .in_x  (op_a),
        .in_y  (op_b),
        .in_z  (op_c),
        .sum_v (s1),
        .cry_v (c1)
    );

    // carry vector carries twice the weight: shift it up one column
    assign l2_x = {1'b0, s1};
    assign l2_y = {c1, 1'b0};
    assign l2_z = {1'b0, op_d};

    csa_compress #(.W(W2)) u_lay2 (
        .in_x  (l2_x),
        .in_y  (l2_y),
        .in_z  (l2_z),
        .sum_v (s2),
        .cry_v (c2)
    );

    assign f_x = {1'b0, s2};
    assign f_y = {c2, 1'b0};

    csa_final_add #(.W(WF)) u_cpa (
        .add_x  (f_x),
        .add_y  (f_y),
        .add_s  (total),
        .add_co (f_co)
    );

endmodule

// File: rtl/quad_csa_checker.sv
module quad_csa_checker #(
    parameter int N = 8
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic [N-1:0] op_c,
    input logic [N-1:0] op_d,
    input logic [N-1:0] s1,
    input logic [N-1:0] c1,
    input logic [N:0]   s2,
    input logic [N:0]   c2,
    input logic         f_co,
    input logic [N+1:0] total
);

    localparam int WC = N + 4;

    logic [WC-1:0] v_in3, v_lay1, v_in4, v_lay2, v_out, v_max;
    logic          known;

    always_comb begin
        v_in3  = WC'(op_a) + WC'(op_b) + WC'(op_c);
        v_lay1 = WC'(s1) + (WC'(c1) << 1);
        v_in4  = v_lay1 + WC'(op_d);
        v_lay2 = WC'(s2) + (WC'(c2) << 1);
        v_out  = WC'(total);
        v_max  = WC'(4) * ((WC'(1) << N) - WC'(1));
        known  = !$isunknown({op_a, op_b, op_c, op_d, s1, c1, s2, c2, f_co, total});
        if (known) begin
            AST_LAY1_VALUE: assert (v_lay1 == v_in3);          // R4
            AST_LAY2_VALUE: assert (v_lay2 == v_in4);          // R5
            AST_NO_OVERFLOW: assert (f_co == 1'b0);            // R6
            AST_TOTAL_BOUND: assert (v_out <= v_max);          // R3
            AST_TOTAL_SUM: assert (v_out == v_in3 + WC'(op_d)); // R1
        end
    end

endmodule

bind quad_csa_adder quad_csa_checker #(.N(N)) u_chk (
    .op_a  (op_a),
    .op_b  (op_b),
    .op_c  (op_c),
    .op_d  (op_d),
    .s1    (s1),
    .c1    (c1),
    .s2    (s2),
    .c2    (c2),
    .f_co  (f_co),
    .total (total)
);

// File: tb/sim_quad_csa_adder.sv
`timescale 1ns/1ps
module sim_quad_csa_adder;

    localparam int N  = 8;
    localparam int NS = 2;
    localparam int NV = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]  a, b, c, d;
    logic [N+1:0]  tot;
    logic [NS-1:0] sa, sb, sc, sd;
    logic [NS+1:0] stot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    quad_csa_adder #(.N(N)) u0 (
        .op_a(a), .op_b(b), .op_c(c), .op_d(d), .total(tot)
    );

    quad_csa_adder #(.N(NS)) u1 (
        .op_a(sa), .op_b(sb), .op_c(sc), .op_d(sd), .total(stot)
    );

    // {a, b, c, d, expected}
    localparam logic [41:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 10'h000},  // R2
        {8'hFF, 8'hFF, 8'hFF, 8'hFF, 10'h3FC},  // R3
        {8'hFF, 8'hFF, 8'hFF, 8'h00, 10'h2FD},  // R4
        {8'h55, 8'hAA, 8'h55, 8'hAA, 10'h1FE},  // R5
        {8'hFF, 8'h01, 8'h00, 8'h00, 10'h100},  // R6
        {8'h01, 8'h00, 8'h00, 8'h00, 10'h001},  // R8
        {8'h00, 8'h00, 8'h00, 8'h80, 10'h080},  // R8
        {8'h00, 8'h00, 8'hC3, 8'h00, 10'h0C3},  // R8
        {8'h12, 8'h34, 8'h56, 8'h78, 10'h114},  // R1
        {8'h80, 8'h80, 8'h80, 8'h80, 10'h200},  // R1
        {8'h01, 8'h01, 8'h01, 8'h01, 10'h004}   // R1
    };

    task automatic chk(input string req, input logic [N+1:0] act, input logic [N+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: total=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] ia, input logic [N-1:0] ib,
                         input logic [N-1:0] ic, input logic [N-1:0] id);
        @(posedge clk);
        a = ia; b = ib; c = ic; d = id;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; c = '0; d = '0;
        sa = '0; sb = '0; sc = '0; sd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", tot, '0);  // quiet inputs during reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][41:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:10]);
            chk("R1", tot, VEC[i][9:0]);
        end

        // R3: top bit set at full scale
        drive('1, '1, '1, '1);
        chk("R3", {9'b0, tot[N+1]}, 10'd1);

        // R9: exhaustive narrow width
        for (int k = 0; k < 256; k++) begin
            logic [NS+1:0] e;
            @(posedge clk);
            sa = k[1:0]; sb = k[3:2]; sc = k[5:4]; sd = k[7:6];
            @(negedge clk);
            e = 4'(sa) + 4'(sb) + 4'(sc) + 4'(sd);
            n_chk++;
            if (stot !== e) begin
                n_fail++;
                $display("FAIL R9: total=%0h expected=%0h", stot, e);
            end
        end

        // R1 random, R7 permutation
        for (int r = 0; r < 300; r++) begin
            logic [N-1:0] ra, rb, rc, rd;
            logic [N+1:0] first;
            ra = N'($urandom); rb = N'($urandom); rc = N'($urandom); rd = N'($urandom);
            drive(ra, rb, rc, rd);
            chk("R1", tot, 10'(ra) + 10'(rb) + 10'(rc) + 10'(rd));
            first = tot;
            drive(rd, rc, ra, rb);
            chk("R7", tot, first);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule